// File: doc/BRIEF.md
# Amplifier Mode and Volume Controller

This block keeps the control state of an audio gain stage: a run/shutdown bit, a mute bit, a stored test flag and a 6-bit volume code. A bus front end that is not part of this block delivers each received control byte as a one-cycle strobe. Bit 7 of the byte chooses the target. When bit 7 is 0 the byte is a mode update. When bit 7 is 1 the byte is a volume update.

The block turns the stored volume code into a signed gain in dB. The step size of this mapping is not uniform, and the upper half of the code space partly repeats the lower half. Mute forces the gain output to -90 dB. Shutdown drops the amplifier/charge-pump enable. Neither one changes the stored volume code, so clearing either condition brings back the previous level. An asynchronous active-low reset returns the block to shutdown at -90 dB.

Top module: `amp_gain_ctrl`

## Requirements
- R1: A strobed byte with bit 7 = 0 loads run from bit 0 (1 = run), mute from bit 1 (1 = muted) and the test flag from bit 4. Bits 2, 3, 5 and 6 have no effect, and the volume code is left unchanged.
- R2: A strobed byte with bit 7 = 1 loads the volume code from bits 5..0. Bit 6 has no effect, and the mode bits are left unchanged.
- R3: Code 0 gives -90 dB. Codes 1..7 give -25, -22, -19, -16, -13, -10 and -8 dB. Codes 7..31 give 2*code-22 dB, so code 11 gives 0 dB and code 31 gives 40 dB.
- R4: Codes 60..63 give 42, 44, 46 and 48 dB.
- R5: Codes 32..42 give the gain of code-32. Codes 43..47 give 0, 4, 8, 12 and 14 dB. Codes 48..59 give 16..38 dB in 2 dB steps.
- R6: While mute is set, gain_db is -90. When mute is cleared, gain_db again follows the stored code.
- R7: amp_en equals the run bit. Shutting down and then running again leaves the stored volume code unchanged.
- R8: While rst_n is low, the block is held at code 0, run 0, mute 0 and test 0, and gain_db reads -90. A strobe that arrives during reset is ignored.
- R9: gain_db is an 8-bit two's-complement register. It takes its new value at the clock edge that samples the strobe, and it holds its value while no strobe arrives.
- R10: vol_alias is high exactly when the stored code is in the range 32..59.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | One-cycle byte strobe |
| wr_byte | input | 8 | Control byte; bit 7 selects mode (0) or volume (1) |
| gain_db | output | 8 | Signed gain in dB |
| amp_en | output | 1 | Amplifier/charge-pump enable |
| mute_on | output | 1 | Mute state |
| test_mode | output | 1 | Stored test flag |
| vol_alias | output | 1 | Stored code is in the aliased range |

## Verification
Two events can land in the same cycle: a write strobe and an assertion of reset. The bench raises rst_n low in the same cycle that it drives a strobe carrying a volume byte or a run/unmute byte. It then checks that every output shows the reset defaults and that the byte has left no trace after reset is released. A further case checks that a mode write which sets mute and a later write that changes the volume do not disturb each other.

// File: rtl/amp_gain_ctrl.sv
module amp_gain_ctrl #(
  parameter int GAIN_W  = 8,
  parameter int MUTE_DB = -90
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_stb,
  input  logic [7:0]               wr_byte,
  output logic signed [GAIN_W-1:0] gain_db,
  output logic                     amp_en,
  output logic                     mute_on,
  output logic                     test_mode,
  output logic                     vol_alias
);
  localparam int CODE_W = 6;
  localparam logic signed [GAIN_W-1:0] MUTE_G = GAIN_W'(MUTE_DB);

  logic [CODE_W-1:0] vol_q, vol_n;
  logic run_q, run_n, mute_q, mute_n, test_q, test_n;
  logic signed [GAIN_W-1:0] gain_q, gain_n;

  function automatic logic signed [GAIN_W-1:0] code_gain(input logic [CODE_W-1:0] c);
    int g;
    logic [4:0] b;
    b = 5'(c);
    if (c >= 6'd60)      g = 2 * int'(c) - 78;
    else if (c >= 6'd48) g = 2 * int'(c) - 80;
    else if (c == 6'd47) g = 14;
    else if (c >= 6'd43) g = 4 * (int'(c) - 43);
    else begin
      if (c >= 6'd32) b = 5'(c - 6'd32);
      if (b == 5'd0)      g = MUTE_DB;
      else if (b < 5'd7)  g = 3 * int'(b) - 28;
      else                g = 2 * int'(b) - 22;
    end
    return GAIN_W'(g);
  endfunction

  always_comb begin
    vol_n  = vol_q;
    run_n  = run_q;
    mute_n = mute_q;
    test_n = test_q;
    if (wr_stb) begin
      if (wr_byte[7]) vol_n = wr_byte[CODE_W-1:0];
      else begin
        run_n  = wr_byte[0];
        mute_n = wr_byte[1];
        test_n = wr_byte[4];
      end
    end
  end

  assign gain_n = mute_n ? MUTE_G : code_gain(vol_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vol_q  <= '0;
      run_q  <= 1'b0;
      mute_q <= 1'b0;
      test_q <= 1'b0;
      gain_q <= MUTE_G;
    end else begin
      vol_q  <= vol_n;
      run_q  <= run_n;
      mute_q <= mute_n;
      test_q <= test_n;
      gain_q <= gain_n;
    end
  end

  assign gain_db   = gain_q;
  assign amp_en    = run_q;
  assign mute_on   = mute_q;
  assign test_mode = test_q;
  assign vol_alias = (vol_q >= 6'd32) && (vol_q <= 6'd59);

  AST_MODE_KEEPS_VOL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !wr_byte[7]) |=> $stable(vol_q)); // R1
  AST_VOL_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_byte[7]) |=> ($stable(run_q) && $stable(mute_q) && $stable(test_q))); // R2
  AST_MUTE_GAIN: assert property (@(posedge clk) disable iff (!rst_n)
    mute_on |-> gain_db == MUTE_G); // R6
  AST_RUN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !wr_byte[7]) |=> amp_en == $past(wr_byte[0])); // R7
  AST_RESET_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (gain_db == MUTE_G && !amp_en && !mute_on && !test_mode)); // R8
  AST_GAIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(gain_db)); // R9
endmodule

// File: tb/amp_gain_ctrl_tb.sv
module amp_gain_ctrl_tb;
  logic clk = 0, rst_n = 0, wr_stb = 0;
  logic [7:0] wr_byte = 0;
  logic signed [7:0] gain_db;
  logic amp_en, mute_on, test_mode, vol_alias;
  int checks = 0, errors = 0;
  int m_vol = 0;
  bit m_run = 0, m_mute = 0, m_test = 0;
  bit done = 0;

  always #2 clk = ~clk;

  amp_gain_ctrl u_dut (.clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_byte(wr_byte),
    .gain_db(gain_db), .amp_en(amp_en), .mute_on(mute_on), .test_mode(test_mode),
    .vol_alias(vol_alias));

  function automatic int exp_gain(int c);
    int lo;
    if (c >= 60) return 42 + 2 * (c - 60);
    if (c >= 48) return 16 + 2 * (c - 48);
    case (c)
      43: return 0; 44: return 4; 45: return 8; 46: return 12; 47: return 14;
      default: ;
    endcase
    lo = (c >= 32) ? c - 32 : c;
    case (lo)
      0: return -90; 1: return -25; 2: return -22; 3: return -19;
      4: return -16; 5: return -13; 6: return -10;
      default: return (lo - 11) * 2;
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk({tag, " R6 gain"}, int'(gain_db), m_mute ? -90 : exp_gain(m_vol));
    chk({tag, " R7 amp_en"}, int'(amp_en), int'(m_run));
    chk({tag, " R1 mute"}, int'(mute_on), int'(m_mute));
    chk({tag, " R1 test"}, int'(test_mode), int'(m_test));
    chk({tag, " R10 alias"}, int'(vol_alias), int'(m_vol >= 32 && m_vol <= 59));
  endtask

  task automatic wr(logic [7:0] b);
    @(negedge clk);
    wr_stb = 1; wr_byte = b;
    @(negedge clk);
    wr_stb = 0; wr_byte = 8'h00;
    if (b[7]) m_vol = int'(b[5:0]);
    else begin m_run = b[0]; m_mute = b[1]; m_test = b[4]; end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_all("reset R8");
    rst_n = 1;
    @(negedge clk);
    check_all("after reset R8");
    wr(8'h81);
    for (int c = 0; c < 64; c++) begin
      wr(8'h80 | 8'(c));
      chk(c < 32 ? "R3 map" : (c >= 60 ? "R4 map" : "R5 map"), int'(gain_db), exp_gain(c));
      chk("R10 alias", int'(vol_alias), int'(c >= 32 && c <= 59));
    end
    wr(8'hC0 | 8'd20);
    check_all("R2 bit6 ignored");
    wr(8'h6D);
    check_all("R1 reserved ignored");
    wr(8'h01);
    check_all("R1 run");
    wr(8'h00);
    check_all("R7 shutdown keeps vol");
    wr(8'h01);
    check_all("R7 rerun");
    wr(8'h03);
    check_all("R6 mute");
    wr(8'h80 | 8'd62);
    check_all("R6 vol under mute");
    wr(8'h01);
    check_all("R6 unmute restores");
    repeat (4) @(negedge clk);
    check_all("R9 hold");
    @(negedge clk);
    wr_stb = 1; wr_byte = 8'h80 | 8'd30;
    @(posedge clk); #1;
    chk("R9 same-edge update", int'(gain_db), 38);
    @(negedge clk); wr_stb = 0; m_vol = 30;
    wr_stb = 1; wr_byte = 8'h80 | 8'd50; rst_n = 0;
    @(negedge clk);
    wr_stb = 1; wr_byte = 8'h13;
    @(negedge clk);
    wr_stb = 0; wr_byte = 0;
    m_vol = 0; m_run = 0; m_mute = 0; m_test = 0;
    check_all("R8 strobe during reset");
    rst_n = 1;
    repeat (2) @(negedge clk);
    check_all("R8 after release");
    process::self().srandom(32'd1234);
    for (int i = 0; i < 400; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      wr(b);
      check_all(b[7] ? "rand R2" : "rand R1");
      if ($urandom_range(3) == 0) begin
        @(negedge clk);
        check_all("rand R9 idle");
      end
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule